// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Hiccup Controller

This block sits between the pulse-width modulator of a step-down converter and the driver of its high-side switch. Every switching period begins with a one-clock cycle-start strobe. For each period the block decides whether the modulator's on-time request reaches the switch, and it reads a digital peak-current comparator once per pulse. The comparator is ignored for a programmable number of system clocks after the switch closes, so that switching noise cannot trip it. The comparator passes through a synchronizer first.

The block reacts to an over-current in one of two ways, chosen by the soft-start-active flag. While soft-start runs, it limits current pulse by pulse. The pulse that faults is cut short, and an adaptive skip count decides how many whole periods stay dark before the next attempt. The count rises by one with every faulting attempt and falls by one with every clean attempt. It saturates at seven, so under a hard short the switch fires on only one period in eight. Once the output is in regulation, an over-current instead cuts the pulse and raises a hiccup request. That request tells the soft-start sequencer to hold its reference at zero for a programmable number of periods (2048 by default). The hiccup also wipes the skip count.

Top module: `ocp_guard`

## Requirements
- R1: While reset is asserted and after its release with `on_req` low, `gate_en`, `skip_now` and `hiccup_req` are all low and the skip count is zero.
- R2: With no over-current, no skipping and no hiccup, `gate_en` follows `on_req` clock for clock.
- R3: The comparator has no effect during the first BLANK_CLKS clocks of an on-time. It is judged only on the clock edge that ends the BLANK_CLKS-th clock of gated on-time, using its value after a SYNC_STAGES-flop synchronizer. A comparator level that starts after that edge has no effect for the rest of the period.
- R4: If the judged comparator value is high, `gate_en` goes low from the next clock for the rest of that period, so the pulse lasts exactly BLANK_CLKS clocks.
- R5: During soft-start, a faulting attempt raises the skip count by one. The next that-many periods are skipped: `skip_now` is high and `gate_en` is low for each whole skipped period. From a zero count, the sequence under a persistent fault is fault, 1 skip, fault, 2 skips, fault, 3 skips.
- R6: The skip count saturates at 7. Under a persistent fault in soft-start, exactly 7 of every 8 periods are skipped.
- R7: A clean attempt (judged comparator low) lowers the skip count by one, down to 0. It starts no skipping.
- R8: An over-current with soft-start inactive cuts the pulse and raises `hiccup_req`. The request stays high until the HICCUP_CYCLES-th cycle-start strobe after the fault and keeps `gate_en` low all that time. The skip count and any pending skips are cleared when the hiccup starts.
- R9: An on-time shorter than BLANK_CLKS clocks is never judged: it changes neither the skip count nor the hiccup state.
- R10: `skip_now` changes only on clock edges where the cycle-start strobe is high, so it is constant across a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| on_req | input | 1 | On-time request from the modulator |
| oc_raw | input | 1 | Asynchronous peak-current comparator output, high on over-current |
| ss_active | input | 1 | High while the soft-start ramp is running |
| gate_en | output | 1 | Enable to the high-side switch driver |
| skip_now | output | 1 | High for a whole period that is being skipped |
| hiccup_req | output | 1 | Request to the soft-start sequencer to hold the reference at zero |

## Verification
The hardest state to reach from the ports is a partly drained skip count that is then re-armed. Seeing the one-step decrement requires bringing the count to saturation, delivering a known number of clean attempts that land only on non-skipped periods, and then faulting again. The bench first saturates the counter with a persistent fault. It then keeps the comparator low and counts clean attempts by watching `skip_now` at mid-period, and faults on the very next attempt. The length of the resulting skip run shows the count directly. A hiccup is entered the same way, from a saturated count, so the bench can also check that the count is wiped.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   // Result of judging the comparator at the end of blanking.
   typedef enum logic [1:0] {
      VERDICT_NONE  = 2'd0,
      VERDICT_CLEAN = 2'd1,
      VERDICT_FAULT = 2'd2
   } verdict_e;

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 0) begin : g_bad_stages
      $error("ocp_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q_sync = d_async;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else if (STAGES == 1) chain_q <= d_async;
         else chain_q <= {chain_q[STAGES-2:0], d_async};
      end
      assign q_sync = chain_q[STAGES-1];
   end

endmodule

// File: rtl/ocp_blank.sv
module ocp_blank
   import ocp_pkg::*;
#(
   parameter int BLANK_CLKS = 40
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cyc_start,
   input  logic     gate_on,
   input  logic     oc_s,
   output verdict_e verdict
);

   localparam int CW = $clog2(BLANK_CLKS + 1);
   localparam logic [CW-1:0] LAST = CW'(BLANK_CLKS - 1);
   localparam logic [CW-1:0] DONE = CW'(BLANK_CLKS);

   if (BLANK_CLKS < 1) begin : g_bad_blank
      $error("ocp_blank: BLANK_CLKS must be at least 1");
   end

   logic [CW-1:0] on_cnt;
   logic          judge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) on_cnt <= '0;
      else if (cyc_start) on_cnt <= '0;
      else if (gate_on && on_cnt != DONE) on_cnt <= on_cnt + 1'b1;
   end

   // One judgement per period, on the last blanked clock of on-time.
   assign judge   = gate_on && !cyc_start && (on_cnt == LAST);
   assign verdict = !judge ? VERDICT_NONE : (oc_s ? VERDICT_FAULT : VERDICT_CLEAN);

   // R3: after a judgement the counter is parked, so no second one follows
   p_single_judge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict != VERDICT_NONE) |=> (verdict == VERDICT_NONE));

endmodule

// File: rtl/ocp_skip.sv
module ocp_skip
   import ocp_pkg::*;
#(
   parameter int SKIP_W = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cyc_start,
   input  logic     ss_active,
   input  logic     wipe,
   input  verdict_e verdict,
   output logic     skip_now
);

   localparam logic [SKIP_W-1:0] KMAX = '1;

   if (SKIP_W < 1) begin : g_bad_width
      $error("ocp_skip: SKIP_W must be at least 1");
   end

   logic [SKIP_W-1:0] skip_k;
   logic [SKIP_W-1:0] skip_left;
   logic [SKIP_W-1:0] k_up;
   logic              fault_ss;

   assign k_up     = (skip_k == KMAX) ? KMAX : skip_k + 1'b1;
   assign fault_ss = (verdict == VERDICT_FAULT) && ss_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_k    <= '0;
         skip_left <= '0;
         skip_now  <= 1'b0;
      end else if (wipe) begin
         skip_k    <= '0;
         skip_left <= '0;
      end else begin
         if (fault_ss) begin
            skip_k    <= k_up;
            skip_left <= k_up;
         end else if (verdict == VERDICT_CLEAN && skip_k != '0) begin
            skip_k <= skip_k - 1'b1;
         end
         if (cyc_start) begin
            skip_now <= (skip_left != '0);
            if (skip_left != '0) skip_left <= skip_left - 1'b1;
         end
      end
   end

   // R5: pending skips never exceed the current count
   p_left_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      skip_left <= skip_k);
   // R6: a saturated count stays saturated on a further fault
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ss && !wipe && skip_k == KMAX) |=> (skip_k == KMAX));
   // R10: the skip flag moves only on a period boundary
   p_skip_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(skip_now));
   // R8: a hiccup start leaves no count behind
   p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (skip_k == '0 && skip_left == '0));

endmodule

// File: rtl/ocp_hiccup.sv
module ocp_hiccup #(
   parameter int HICCUP_CYCLES = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cyc_start,
   output logic active
);

   localparam int HW = $clog2(HICCUP_CYCLES + 1);
   localparam logic [HW-1:0] LOAD = HW'(HICCUP_CYCLES);

   if (HICCUP_CYCLES < 1) begin : g_bad_len
      $error("ocp_hiccup: HICCUP_CYCLES must be at least 1");
   end

   logic [HW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left_q <= '0;
      else if (start) left_q <= LOAD;
      else if (cyc_start && left_q != '0) left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);

   // R8: a started hiccup is visible on the next clock
   p_hic_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> active);
   // R8: the request only ends on a period boundary
   p_hic_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cyc_start) |=> active);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
   import ocp_pkg::*;
#(
   parameter int BLANK_CLKS    = 40,
   parameter int SYNC_STAGES   = 2,
   parameter int SKIP_W        = 3,
   parameter int HICCUP_CYCLES = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic on_req,
   input  logic oc_raw,
   input  logic ss_active,
   output logic gate_en,
   output logic skip_now,
   output logic hiccup_req
);

   logic     oc_s;
   verdict_e verdict;
   logic     fault;
   logic     hic_start;
   logic     cut_q;

   ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(oc_raw),
      .q_sync (oc_s)
   );

   ocp_blank #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .gate_on  (gate_en),
      .oc_s     (oc_s),
      .verdict  (verdict)
   );

   assign fault     = (verdict == VERDICT_FAULT);
   assign hic_start = fault && !ss_active;

   ocp_skip #(.SKIP_W(SKIP_W)) u_skip (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_start(cyc_start),
      .ss_active(ss_active),
      .wipe     (hic_start),
      .verdict  (verdict),
      .skip_now (skip_now)
   );

   ocp_hiccup #(.HICCUP_CYCLES(HICCUP_CYCLES)) u_hiccup (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (hic_start),
      .cyc_start(cyc_start),
      .active   (hiccup_req)
   );

   // Pulse truncation: held until the next period begins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cut_q <= 1'b0;
      else if (cyc_start) cut_q <= 1'b0;
      else if (fault) cut_q <= 1'b1;
   end

   assign gate_en = on_req && !skip_now && !cut_q && !hiccup_req;

   // R4: a judged fault ends the pulse on the next clock
   p_fault_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !gate_en);
   // R5: a skipped period never conducts
   p_skip_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      skip_now |-> !gate_en);
   // R8: no conduction during a hiccup
   p_hic_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup_req |-> !gate_en);
   // R5: a fault during soft-start never starts a hiccup
   p_ss_no_hic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && ss_active && !hiccup_req) |=> !hiccup_req);

endmodule

// File: tb/tb_ocp_guard.sv
`timescale 1ns/1ps
module tb_ocp_guard;

   localparam int B   = 4;
   localparam int HIC = 6;
   localparam int P   = 12;
   localparam int KM  = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 1'b0, on_req = 1'b0, oc_raw = 1'b0, ss_active = 1'b0;
   logic gate_en, skip_now, hiccup_req;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit lockstep = 1'b0;

   // reference model state
   int  m_cnt = 0, m_k = 0, m_rem = 0, m_hic = 0;
   bit  m_cut = 0, m_skip = 0, m_s1 = 0, m_s2 = 0;

   always #2.5 clk = ~clk;

   ocp_guard #(.BLANK_CLKS(B), .SYNC_STAGES(2), .SKIP_W(3), .HICCUP_CYCLES(HIC)) dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .on_req(on_req),
      .oc_raw(oc_raw), .ss_active(ss_active),
      .gate_en(gate_en), .skip_now(skip_now), .hiccup_req(hiccup_req)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_k = 0; m_rem = 0; m_hic = 0;
         m_cut = 0; m_skip = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         bit g, judged, bad;
         g      = on_req && !m_skip && !m_cut && (m_hic == 0);
         judged = g && !cyc_start && (m_cnt == B - 1);
         bad    = judged && m_s2;
         m_s2 = m_s1;
         m_s1 = oc_raw;
         if (cyc_start) m_cnt = 0;
         else if (g && m_cnt < B) m_cnt++;
         if (cyc_start) m_cut = 0;
         else if (bad) m_cut = 1;
         if (bad && !ss_active) begin
            m_hic = HIC; m_k = 0; m_rem = 0;
         end else begin
            if (cyc_start && m_hic > 0) m_hic--;
            if (bad) begin
               m_k = (m_k < KM) ? m_k + 1 : KM;
               m_rem = m_k;
            end else if (judged) begin
               m_k = (m_k > 0) ? m_k - 1 : 0;
            end
            if (cyc_start) begin
               m_skip = (m_rem > 0);
               if (m_rem > 0) m_rem--;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit eg;
      eg = on_req && !m_skip && !m_cut && (m_hic == 0);
      check(gate_en === eg, tag, "gate_en", int'(gate_en), int'(eg));
      check(skip_now === m_skip, tag, "skip_now", int'(skip_now), int'(m_skip));
      check(hiccup_req === (m_hic != 0), tag, "hiccup_req", int'(hiccup_req), int'(m_hic != 0));
   endtask

   task automatic step(input bit cs, input bit on, input bit oc, input bit ss);
      @(negedge clk);
      if (lockstep) compare();
      cyc_start = cs; on_req = on; oc_raw = oc; ss_active = ss;
      #1;
   endtask

   task automatic run_cycle(input int on_len, input int oc_a, input int oc_b, input bit ss,
                            output bit skip_mid, output bit hic_mid, output int gcnt,
                            output bit skip_flat);
      bit s_first;
      gcnt = 0; s_first = 0; skip_mid = 0; hic_mid = 0; skip_flat = 1;
      for (int i = 0; i < P; i++) begin
         step(i == 0, (i >= 1 && i <= on_len), (i >= oc_a && i < oc_b), ss);
         if (gate_en) gcnt++;
         if (i == 1) s_first = skip_now;
         if (i == 8) begin skip_mid = skip_now; hic_mid = hiccup_req; end
         if (i == P - 1) skip_flat = (skip_now == s_first);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit sm, hm, sf;
      int gc, cnt, nclean;
      bit pat [9];
      bit exp_pat [9] = '{0, 1, 0, 1, 1, 0, 1, 1, 1};

      // R1: reset state
      repeat (3) @(negedge clk);
      check(gate_en === 1'b0 && skip_now === 1'b0 && hiccup_req === 1'b0, "R1",
            "outputs in reset", int'({gate_en, skip_now, hiccup_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gate_en === 1'b0 && skip_now === 1'b0 && hiccup_req === 1'b0, "R1",
            "outputs after reset", int'({gate_en, skip_now, hiccup_req}), 0);
      lockstep = 1'b1;

      // R2: clean pulses of several lengths pass through
      tag = "R2";
      run_cycle(3, 0, 0, 1, sm, hm, gc, sf);  check(gc == 3, "R2", "gate clocks len3", gc, 3);
      run_cycle(8, 0, 0, 1, sm, hm, gc, sf);  check(gc == 8, "R2", "gate clocks len8", gc, 8);
      run_cycle(10, 0, 0, 1, sm, hm, gc, sf); check(gc == 10, "R2", "gate clocks len10", gc, 10);

      // R3: comparator high only during blanking, then only after the judgement
      tag = "R3";
      run_cycle(8, 0, 2, 1, sm, hm, gc, sf);  check(gc == 8, "R3", "early glitch ignored", gc, 8);
      run_cycle(8, 5, P, 1, sm, hm, gc, sf);  check(gc == 8, "R3", "late level ignored", gc, 8);
      run_cycle(8, 0, 0, 1, sm, hm, gc, sf);  check(sm == 0, "R3", "no skip after blanked glitch", sm, 0);

      // R4 + R5: persistent fault from a zero count
      tag = "R5";
      for (int c = 0; c < 9; c++) begin
         run_cycle(8, 0, P, 1, sm, hm, gc, sf);
         pat[c] = sm;
         if (c == 0) check(gc == B, "R4", "truncated pulse length", gc, B);
         check(sf, "R10", "skip_now constant in period", int'(sf), 1);
      end
      for (int c = 0; c < 9; c++) check(pat[c] == exp_pat[c], "R5", "skip pattern", pat[c], exp_pat[c]);

      // R6: saturation, 7 of 8 periods skipped
      tag = "R6";
      for (int c = 0; c < 40; c++) run_cycle(8, 0, P, 1, sm, hm, gc, sf);
      cnt = 0;
      for (int c = 0; c < 16; c++) begin
         run_cycle(8, 0, P, 1, sm, hm, gc, sf);
         if (sm) cnt++;
      end
      check(cnt == 14, "R6", "skipped periods out of 16", cnt, 14);

      // R7: three clean attempts lower 7 to 4, next fault gives 5 skips
      tag = "R7";
      nclean = 0;
      for (int c = 0; c < 20 && nclean < 3; c++) begin
         run_cycle(8, 0, 0, 1, sm, hm, gc, sf);
         if (!sm) nclean++;
      end
      check(nclean == 3, "R7", "clean attempts seen", nclean, 3);
      run_cycle(8, 0, P, 1, sm, hm, gc, sf);
      check(sm == 0 && gc == B, "R7", "refault attempt length", gc, B);
      cnt = 0;
      for (int c = 0; c < 6; c++) begin
         run_cycle(8, 0, P, 1, sm, hm, gc, sf);
         if (sm) cnt++;
         if (c == 5) check(sm == 0, "R7", "attempt after 5 skips", sm, 0);
      end
      check(cnt == 5, "R7", "skip run after decrement", cnt, 5);

      // R8: fault outside soft-start starts a hiccup
      tag = "R8";
      hm = 0;
      for (int c = 0; c < 12 && !hm; c++) run_cycle(8, 0, P, 0, sm, hm, gc, sf);
      check(hm == 1, "R8", "hiccup raised", hm, 1);
      cnt = 1;
      for (int c = 0; c < HIC + 1; c++) begin
         run_cycle(8, 0, 0, 0, sm, hm, gc, sf);
         if (hm) begin
            cnt++;
            check(gc == 0, "R8", "gate dark in hiccup", gc, 0);
         end
      end
      check(cnt == HIC, "R8", "hiccup length in periods", cnt, HIC);
      run_cycle(8, 0, P, 1, sm, hm, gc, sf);
      run_cycle(8, 0, P, 1, sm, hm, gc, sf);
      check(sm == 1, "R8", "first skip after wipe", sm, 1);
      run_cycle(8, 0, P, 1, sm, hm, gc, sf);
      check(sm == 0, "R8", "count restarted at one", sm, 0);

      // R9: pulses shorter than blanking are never judged
      tag = "R9";
      cnt = 0;
      for (int c = 0; c < 10; c++) begin
         run_cycle(2, 0, P, 1, sm, hm, gc, sf);
         if (c >= 4 && sm) cnt++;
      end
      check(cnt == 0, "R9", "skips from short pulses", cnt, 0);
      cnt = 0;
      for (int c = 0; c < 3; c++) begin
         run_cycle(2, 0, P, 0, sm, hm, gc, sf);
         if (hm) cnt++;
      end
      check(cnt == 0, "R9", "hiccups from short pulses", cnt, 0);

      step(0, 0, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule